// File: doc/BRIEF.md
# Wiper position controller

This block is the digital side of a digitally controlled potentiometer. A host steers it with three level inputs: an active-low select, a direction level and an increment strobe. All three are synchronised to the system clock. While the block is selected, each falling edge of the strobe moves a wiper position counter one step up or down. The counter covers `NUM_TAPS` positions and stops at both ends instead of wrapping. The position is decoded to a one-hot select vector of `NUM_TAPS` lines, which stands in for the tap switches.

A shadow register models the nonvolatile copy of the position. When the select input rises while the strobe is high, the counter is committed to the shadow register. The block then stays busy for `STORE_CYCLES` clocks and ignores its inputs during that time. When the select input rises while the strobe is low, the block is released without a commit.

There are two resets. The warm reset `rst_n` reloads the counter from the shadow register, the way a power cycle recalls the stored value. The power-on reset `por_n` puts both the counter and the shadow register at `DEFAULT_POS`.

Top module: `wiper_ctrl`

## Requirements
- R1: While the synchronised select input is high, strobe edges and direction changes leave the position unchanged.
- R2: While selected, a falling edge of the strobe raises the position by one when `up_i` is 1 and lowers it by one when `up_i` is 0.
- R3: The position stays within 0 to `NUM_TAPS-1`. `tap_sel_o` has exactly one bit set, and that bit's index equals `wiper_pos_o`.
- R4: A step down at position 0 leaves it at 0. A step up at `NUM_TAPS-1` leaves it at `NUM_TAPS-1`.
- R5: A rising edge of the select input while the strobe is high copies the position into the shadow register. A later warm reset brings that value back.
- R6: A rising edge of the select input while the strobe is low stores nothing. The current position is kept.
- R7: `por_n` low sets the position and the shadow register to `DEFAULT_POS`. `rst_n` low at a clock edge loads the position from the shadow register.
- R8: The direction level may change while the block stays selected. The next strobe edge uses the new direction.
- R9: After a commit, `busy_o` is 1 for exactly `STORE_CYCLES` clocks. During that window, strobe edges and select edges have no effect.
- R10: An input change made before clock edge k shows on `wiper_pos_o` after edge k+2 and not earlier: two synchroniser flops plus the counter register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous warm reset, active low; recalls the stored position |
| cs_n_i | input | 1 | Select, active low, asynchronous to clk |
| up_i | input | 1 | Direction: 1 steps up, 0 steps down |
| inc_i | input | 1 | Step strobe; acts on its falling edge |
| wiper_pos_o | output | $clog2(NUM_TAPS) | Current wiper position |
| tap_sel_o | output | NUM_TAPS | One-hot tap select |
| busy_o | output | 1 | Commit in progress |

## Verification
Strobe pulses are sent with the select input high and then with it low. This separates a block that gates on select from one that does not. Step runs in each direction reach and go past both ends, which shows saturation against wrap-around. A direction flip in the middle of a session checks that direction is sampled per edge. A commit deselect is followed by a no-commit deselect, and then a warm reset. The value that comes back shows which of the two deselects wrote the shadow register. A strobe pulse sent during the busy window, and a single edge timed against the clock, expose a missing busy gate and wrong synchroniser latency.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef struct packed {
    logic cs_n;
    logic up;
    logic inc;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, up: 1'b0, inc: 1'b1};
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = chain[g-1];
    end
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      chain[g] <= IDLE;
      else if (!rst_n) chain[g] <= IDLE;
      else             chain[g] <= src;
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wpc_core.sv
module wpc_core
  import wpc_pkg::*;
#(
  parameter int NUM_TAPS = 100,
  parameter int DEFAULT_POS = 0,
  parameter int STORE_CYCLES = 8,
  localparam int POS_W = $clog2(NUM_TAPS),
  localparam int BUSY_W = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  ctl_t             ctl_s,
  output logic [POS_W-1:0] pos_o,
  output logic             busy_o
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(NUM_TAPS - 1);
  localparam logic [POS_W-1:0] POS_DEF = POS_W'(DEFAULT_POS);

  logic [POS_W-1:0]  pos_q, shadow_q;
  logic [BUSY_W-1:0] busy_cnt;
  logic              cs_prev, inc_prev;
  logic              inc_fall, cs_rise, busy;

  assign inc_fall = inc_prev & ~ctl_s.inc;
  assign cs_rise  = ~cs_prev & ctl_s.cs_n;
  assign busy     = (busy_cnt != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pos_q    <= POS_DEF;
      shadow_q <= POS_DEF;
      busy_cnt <= '0;
      cs_prev  <= 1'b1;
      inc_prev <= 1'b1;
    end else if (!rst_n) begin
      pos_q    <= shadow_q;
      busy_cnt <= '0;
      cs_prev  <= 1'b1;
      inc_prev <= 1'b1;
    end else begin
      cs_prev  <= ctl_s.cs_n;
      inc_prev <= ctl_s.inc;
      if (busy) begin
        busy_cnt <= busy_cnt - BUSY_W'(1);
      end else if (!ctl_s.cs_n && inc_fall) begin
        if (ctl_s.up) begin
          if (pos_q != POS_MAX) pos_q <= pos_q + POS_W'(1);
        end else begin
          if (pos_q != '0) pos_q <= pos_q - POS_W'(1);
        end
      end else if (cs_rise && ctl_s.inc) begin
        shadow_q <= pos_q;
        busy_cnt <= BUSY_W'(STORE_CYCLES);
      end
    end
  end

  assign pos_o  = pos_q;
  assign busy_o = busy;

  assert_in_range_R3: assert property (@(posedge clk) disable iff (!por_n)
    pos_q <= POS_MAX);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!por_n)
    rst_n |=> (int'(pos_q) - int'($past(pos_q)) <= 1) &&
              (int'($past(pos_q)) - int'(pos_q) <= 1));

  assert_hold_deselected_R1: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && ctl_s.cs_n) |=> $stable(pos_q));

  assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && busy) |=> ($stable(pos_q) && $stable(shadow_q)));
endmodule

// File: rtl/wpc_decode.sv
module wpc_decode #(
  parameter int NUM_TAPS = 100,
  localparam int POS_W = $clog2(NUM_TAPS)
) (
  input  logic [POS_W-1:0]    pos_i,
  output logic [NUM_TAPS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign sel_o[g] = (pos_i == POS_W'(g));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wpc_pkg::*;
#(
  parameter int NUM_TAPS = 100,
  parameter int DEFAULT_POS = 0,
  parameter int STORE_CYCLES = 8,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_n,
  input  logic                cs_n_i,
  input  logic                up_i,
  input  logic                inc_i,
  output logic [POS_W-1:0]    wiper_pos_o,
  output logic [NUM_TAPS-1:0] tap_sel_o,
  output logic                busy_o
);
  localparam int CW = $bits(ctl_t);

  ctl_t          ctl_raw, ctl_s;
  logic [CW-1:0] ctl_sync;

  assign ctl_raw = '{cs_n: cs_n_i, up: up_i, inc: inc_i};

  wpc_sync #(.WIDTH(CW), .STAGES(SYNC_STAGES), .IDLE(CW'(CTL_IDLE))) u_sync (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .d_i(CW'(ctl_raw)), .q_o(ctl_sync)
  );

  assign ctl_s = ctl_t'(ctl_sync);

  wpc_core #(.NUM_TAPS(NUM_TAPS), .DEFAULT_POS(DEFAULT_POS), .STORE_CYCLES(STORE_CYCLES)) u_core (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ctl_s(ctl_s),
    .pos_o(wiper_pos_o), .busy_o(busy_o)
  );

  wpc_decode #(.NUM_TAPS(NUM_TAPS)) u_dec (
    .pos_i(wiper_pos_o), .sel_o(tap_sel_o)
  );

  assert_onehot_match_R3: assert property (@(posedge clk) disable iff (!por_n)
    $onehot(tap_sel_o) && tap_sel_o[wiper_pos_o]);
endmodule

// File: tb/wiper_ctrl_test.sv
module wiper_ctrl_test;
  localparam int NUM = 100;
  localparam int DEF = 0;
  localparam int STORE = 8;
  localparam int PW = $clog2(NUM);

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1;
  logic cs_n = 1'b1, up = 1'b0, inc = 1'b1;
  logic [PW-1:0]  wiper_pos;
  logic [NUM-1:0] tap_sel;
  logic           busy;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wiper_ctrl #(.NUM_TAPS(NUM), .DEFAULT_POS(DEF), .STORE_CYCLES(STORE)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_n_i(cs_n), .up_i(up), .inc_i(inc),
    .wiper_pos_o(wiper_pos), .tap_sel_o(tap_sel), .busy_o(busy)
  );

  // Reference model: input history queues, newest sample at index 0
  int m_pos, m_shadow, m_busy;
  bit h_cs[$], h_up[$], h_inc[$];

  task automatic hist_idle();
    h_cs = '{1, 1, 1}; h_up = '{0, 0, 0}; h_inc = '{1, 1, 1};
  endtask

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_pos = DEF; m_shadow = DEF; m_busy = 0;
      hist_idle();
    end else if (!rst_n) begin
      m_pos = m_shadow; m_busy = 0;
      hist_idle();
    end else begin
      if (m_busy > 0) begin
        m_busy--;
      end else if (!h_cs[1] && h_inc[2] && !h_inc[1]) begin
        if (h_up[1]) m_pos = (m_pos < NUM - 1) ? m_pos + 1 : m_pos;
        else         m_pos = (m_pos > 0) ? m_pos - 1 : 0;
      end else if (!h_cs[2] && h_cs[1] && h_inc[1]) begin
        m_shadow = m_pos;
        m_busy = STORE;
      end
      h_cs.push_front(cs_n);   void'(h_cs.pop_back());
      h_up.push_front(up);     void'(h_up.pop_back());
      h_inc.push_front(inc);   void'(h_inc.pop_back());
    end
  end

  always @(negedge clk) begin
    if (por_n && !done) begin
      logic [NUM-1:0] exp_sel;
      exp_sel = '0;
      exp_sel[m_pos] = 1'b1;
      compared += 3;
      if (int'(wiper_pos) != m_pos) begin
        mismatched++;
        $display("FAIL R2 model position: actual %0d expected %0d", wiper_pos, m_pos);
      end
      if (tap_sel !== exp_sel) begin
        mismatched++;
        $display("FAIL R3 tap select: actual %h expected %h", tap_sel, exp_sel);
      end
      if (busy !== (m_busy != 0)) begin
        mismatched++;
        $display("FAIL R9 busy: actual %0b expected %0b", busy, m_busy != 0);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      inc = 1'b0; wait_cyc(4);
      inc = 1'b1; wait_cyc(4);
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    wait_cyc(3);
    por_n = 1'b1;
    wait_cyc(2);
    chk("R7 power-on position", wiper_pos, DEF);
    chk("R3 power-on select bit", tap_sel[DEF], 1);
    chk("R9 idle busy", busy, 0);

    // R1: strobes and direction changes while deselected
    up = 1'b1; pulse(3); up = 1'b0; pulse(1); wait_cyc(4);
    chk("R1 deselected strobes", wiper_pos, 0);

    // R10: latency of one edge
    cs_n = 1'b0; up = 1'b1; wait_cyc(4);
    inc = 1'b0; wait_cyc(2);
    chk("R10 before third edge", wiper_pos, 0);
    wait_cyc(1);
    chk("R10 at third edge", wiper_pos, 1);
    inc = 1'b1; wait_cyc(4);

    pulse(4);
    chk("R2 step up", wiper_pos, 5);
    up = 1'b0; pulse(2);
    chk("R8 direction flip", wiper_pos, 3);
    pulse(5);
    chk("R4 floor", wiper_pos, 0);
    up = 1'b1; pulse(NUM + 5);
    chk("R4 ceiling", wiper_pos, NUM - 1);
    chk("R3 top select bit", tap_sel[NUM-1], 1);
    chk("R3 single select bit", $countones(tap_sel), 1);

    up = 1'b0; pulse(2);
    chk("R2 step down", wiper_pos, NUM - 3);

    // R5 commit, R9 busy window
    cs_n = 1'b1; wait_cyc(3);
    chk("R9 busy raised", busy, 1);
    cs_n = 1'b0; inc = 1'b0; wait_cyc(4);
    inc = 1'b1; wait_cyc(6);
    chk("R9 strobe ignored while busy", wiper_pos, NUM - 3);
    chk("R9 busy cleared", busy, 0);

    pulse(1);
    chk("R2 step after busy", wiper_pos, NUM - 4);

    // R6: deselect with strobe low
    inc = 1'b0; wait_cyc(4);
    cs_n = 1'b1; wait_cyc(6);
    chk("R6 no commit keeps position", wiper_pos, NUM - 5);
    chk("R6 no busy", busy, 0);
    inc = 1'b1; wait_cyc(3);

    rst_n = 1'b0; wait_cyc(1);
    rst_n = 1'b1; wait_cyc(2);
    chk("R5 recalled committed value", wiper_pos, NUM - 3);
    chk("R7 warm reset select bit", tap_sel[NUM-3], 1);

    por_n = 1'b0; wait_cyc(2);
    por_n = 1'b1; wait_cyc(2);
    chk("R7 power-on clears shadow", wiper_pos, DEF);
    rst_n = 1'b0; wait_cyc(1);
    rst_n = 1'b1; wait_cyc(2);
    chk("R7 recall after power-on", wiper_pos, DEF);

    summary();
  end
endmodule